// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block is an up-counting timer that also drives a synchronisation strobe, `trgo`, for neighbouring timers. A prescaler divides the clock. The main counter runs from zero up to an active reload limit and then wraps. The prescaler divisor and the reload limit are each written into a preload register. They move into active copies only when an update event occurs. Software controls the timer through a narrow write/read register port. It can enable counting, block update events, and force an immediate update. It also picks what the strobe carries through a 3-bit selector.

Two side inputs model a controlling timer. `slave_rst` restarts the counter and the prescaler. `pause_trig` enables counting while it is high, even when the software enable bit is clear. The strobe is one of three things: a one-clock restart pulse, the effective count-enable level, or the update event. It is always registered, so it appears one clock after its cause.

Register map (word address, fields): 0 = control A {bit1 update-block, bit0 run}; 1 = control B {bits 6:4 strobe selector}; 2 = event {bit0 force-update, write-only}; 3 = prescaler preload; 4 = reload preload; 5 = counter value (read-only).

Top module: `tmr_trig_sel`

## Requirements
- R1: After reset, every register and the counter read 0, and `trgo` is low.
- R2: While counting is enabled, the prescaler advances every clock. With an active divisor P, the counter advances once every P+1 clocks. After it reaches the active reload value, it returns to 0 on its next advance.
- R3: When update-block (address 0, bit 1) is 0, a counter wrap is an update event. An update event copies both preload registers into the active copies, so a new reload value takes effect only after the next wrap or forced update.
- R4: When update-block is 1, no update event occurs and the active copies keep their values. The counter still wraps at the old active reload.
- R5: Writing 1 to address 2, bit 0 restarts the counter and the prescaler at the second clock edge after the write. If update-block is 0, it also produces an update event. The bit clears itself after one clock, and address 2 always reads 0.
- R6: A high `slave_rst` restarts the counter and the prescaler at that clock edge. If update-block is 0, it also produces an update event.
- R7: With selector 000, `trgo` is high for one clock, one clock after each forced update or `slave_rst` cycle.
- R8: With selector 001, `trgo` follows (run OR `pause_trig`) with one clock of latency.
- R9: With selector 010, `trgo` follows the update event with one clock of latency.
- R10: With selectors 011 through 111, `trgo` is low.
- R11: Address 1 reads back only bits 6:4. Address 0 reads back only bits 1:0. All other bits of both read as zero.
- R12: When run is 0 and `pause_trig` is low, the counter and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| slave_rst | input | 1 | Restart request from a controlling timer |
| pause_trig | input | 1 | Count-enable level from a controlling timer |
| trgo | output | 1 | Registered synchronisation strobe |

## Verification
The hardest case to reach is a coincidence of events in a single clock: a wrap together with a forced update or a `slave_rst`, while a preload write lands at the same time. Reaching it requires small active divisors and reload limits, so that wraps are frequent. After the directed phases, a long random phase keeps both limits below 8. It drives `slave_rst`, `pause_trig` and register writes, including flips of the update-block bit, with independent probabilities. A behavioural model predicts `trgo` and the counter value on every clock.

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        slave_rst,
  input  logic        pause_trig,
  output logic        trgo
);
  localparam logic [2:0] A_CTLA = 3'd0, A_CTLB = 3'd1, A_EVT = 3'd2,
                         A_PSC = 3'd3, A_RLD = 3'd4, A_CNT = 3'd5;

  logic             run_en, upd_blk, ug_q;
  logic [2:0]       msel;
  logic [PSC_W-1:0] psc_pre, psc_act, psc_cnt;
  logic [CNT_W-1:0] rld_pre, rld_act, cnt;

  wire cnt_en  = run_en | pause_trig;
  wire restart = ug_q | slave_rst;
  wire tick    = cnt_en && (psc_cnt == psc_act);
  wire wrap    = tick && (cnt == rld_act);
  wire upd_ev  = !upd_blk && (wrap || restart);
  wire wr_hit_evt = wr_en && wr_addr == A_EVT && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      upd_blk <= 1'b0;
      msel    <= 3'd0;
      ug_q    <= 1'b0;
      psc_pre <= '0;
      rld_pre <= '0;
    end else begin
      ug_q <= wr_hit_evt;
      if (wr_en) begin
        case (wr_addr)
          A_CTLA: begin run_en <= wr_data[0]; upd_blk <= wr_data[1]; end
          A_CTLB: msel <= wr_data[6:4];
          A_PSC:  psc_pre <= wr_data[PSC_W-1:0];
          A_RLD:  rld_pre <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      rld_act <= '0;
    end else if (upd_ev) begin
      psc_act <= psc_pre;
      rld_act <= rld_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else if (restart) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else if (cnt_en) begin
      if (tick) begin
        psc_cnt <= '0;
        cnt     <= wrap ? '0 : cnt + 1'b1;
      end else begin
        psc_cnt <= psc_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trgo <= 1'b0;
    else begin
      case (msel)
        3'd0:    trgo <= restart;
        3'd1:    trgo <= cnt_en;
        3'd2:    trgo <= upd_ev;
        default: trgo <= 1'b0;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTLA:  rd_data = {14'd0, upd_blk, run_en};
      A_CTLB:  rd_data = {9'd0, msel, 4'd0};
      A_PSC:   rd_data = 16'(psc_pre);
      A_RLD:   rd_data = 16'(rld_pre);
      A_CNT:   rd_data = 16'(cnt);
      default: rd_data = 16'd0;
    endcase
  end

  // R10
  reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel > 3'd2) |=> !trgo);

  // R5
  ug_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ug_q && !wr_hit_evt) |=> !ug_q);

  // R4
  frozen_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_blk |=> ($stable(rld_act) && $stable(psc_act)));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel == 3'd0 && restart) |=> trgo);

  // R8
  en_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel == 3'd1) |=> (trgo == $past(run_en | pause_trig)));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= rld_act);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !restart) |=> $stable(cnt));
endmodule

// File: tb/tmr_trig_sel_tb.sv
`timescale 1ns/1ps
module tmr_trig_sel_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0, rd_addr = 3'd5;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic        slave_rst = 1'b0, pause_trig = 1'b0;
  logic        trgo;

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_on = 1'b0;
  string tag = "R2";

  int m_run, m_ud, m_ms, m_ug, m_ppre, m_rpre, m_pact, m_ract, m_pc, m_cnt, m_trgo;

  always #2.5 clk = ~clk;

  tmr_trig_sel dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slave_rst(slave_rst),
    .pause_trig(pause_trig), .trgo(trgo)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ud = 0; m_ms = 0; m_ug = 0; m_ppre = 0; m_rpre = 0;
      m_pact = 0; m_ract = 0; m_pc = 0; m_cnt = 0; m_trgo = 0;
    end else begin
      int en, rs, tk, wp, up;
      en = m_run | int'(pause_trig);
      rs = m_ug | int'(slave_rst);
      tk = (en != 0 && m_pc == m_pact) ? 1 : 0;
      wp = (tk != 0 && m_cnt == m_ract) ? 1 : 0;
      up = (m_ud == 0 && (wp != 0 || rs != 0)) ? 1 : 0;
      if (m_ms == 0) m_trgo = rs;
      else if (m_ms == 1) m_trgo = en;
      else if (m_ms == 2) m_trgo = up;
      else m_trgo = 0;
      if (rs != 0) begin m_pc = 0; m_cnt = 0; end
      else if (en != 0) begin
        if (tk != 0) begin m_pc = 0; m_cnt = (wp != 0) ? 0 : (m_cnt + 1) % 65536; end
        else m_pc = m_pc + 1;
      end
      if (up != 0) begin m_pact = m_ppre; m_ract = m_rpre; end
      m_ug = (wr_en && wr_addr == 3'd2 && wr_data[0]) ? 1 : 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_run = int'(wr_data[0]); m_ud = int'(wr_data[1]); end
          3'd1: m_ms = int'(wr_data[6:4]);
          3'd3: m_ppre = int'(wr_data);
          3'd4: m_rpre = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  function automatic string mode_tag(int ms);
    if (ms == 0) return "R7";
    if (ms == 1) return "R8";
    if (ms == 2) return "R9";
    return "R10";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // one cycle: compare at the falling edge, outputs settled
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      if (cmp_on) begin
        chk(mode_tag(m_ms), int'(trgo), m_trgo);
        chk(tag, int'(rd_data), m_cnt);
      end
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, int exp);
    rd_addr = a; #0.5;
    chk(req, int'(rd_data), exp);
    rd_addr = 3'd5;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    for (int a = 0; a < 6; a++) rd_chk("R1", 3'(a), 0);
    chk("R1", int'(trgo), 0);
    cmp_on = 1'b1;

    tag = "R12"; step(5);
    tag = "R5";
    wr(3'd3, 16'd1); wr(3'd4, 16'd4);
    wr(3'd1, 16'h0020);
    wr(3'd2, 16'd1);
    rd_chk("R5", 3'd2, 0);
    step(3);
    tag = "R2"; wr(3'd0, 16'd1); step(30);
    tag = "R3"; wr(3'd4, 16'd2); step(30);
    wr(3'd3, 16'd0); step(20);
    tag = "R4"; wr(3'd0, 16'd3); wr(3'd4, 16'd6); wr(3'd3, 16'd2); step(40);
    wr(3'd2, 16'd1); step(10);
    tag = "R6"; slave_rst = 1'b1; step(); slave_rst = 1'b0; step(8);
    wr(3'd0, 16'd1); step(4);
    slave_rst = 1'b1; step(); slave_rst = 1'b0; step(12);
    tag = "R6"; wr(3'd1, 16'h0000); step(3);
    slave_rst = 1'b1; step(); slave_rst = 1'b0; step(3);
    wr(3'd2, 16'd1); step(4);
    tag = "R12"; wr(3'd1, 16'h0010); wr(3'd0, 16'd0); step(6);
    pause_trig = 1'b1; step(7); pause_trig = 1'b0; step(5);
    wr(3'd0, 16'd1); step(4); wr(3'd0, 16'd0); step(4);
    tag = "R2"; wr(3'd1, 16'h0050); wr(3'd0, 16'd1); step(20);
    wr(3'd1, 16'hFFFF);
    rd_chk("R11", 3'd1, 16'h0070);
    wr(3'd0, 16'hFFFD);
    rd_chk("R11", 3'd0, 1);
    step(10);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      slave_rst = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 9) == 0) pause_trig = ~pause_trig;
      if (r < 12) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom_range(0, 4));
        wr_data = 16'($urandom);
        if (wr_addr >= 3'd3) wr_data = wr_data & 16'h0007;
        if (wr_addr == 3'd0) wr_data[0] = ($urandom_range(0, 3) != 0);
      end else wr_en = 1'b0;
      step();
    end
    wr_en = 1'b0; slave_rst = 1'b0;
    step(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule